// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address by walking a two-level table of 4 KB pages held in memory. A requester presents a linear address along with two attributes: whether the access is a write, and whether it comes from user mode. The walker then reads the directory entry through a word-wide memory request/response port. It reads the table entry next and checks the permission bits of both levels. It returns either the physical address or a page-fault report.

Both levels of entry carry hardware-maintained bits. The walker sets the accessed bit in an entry it uses, and sets the dirty bit in the leaf on a write. It writes an entry back only when one of those bits actually changes, so a single walk costs at most two reads and two writes. The physical base of the directory sits in a root register. Software loads that register through a side port, and a load takes effect only when it carries privilege ring 0. A walk captures the root value when its request is accepted.

The sequencer has eight states. IDLE accepts a request (IDLE→DIR_RD). DIR_RD issues the directory read (→DIR_WT once the port is ready). DIR_WT waits for the data and takes one of three exits. It goes to REPORT if the entry is not present, to DIR_WB if the accessed bit is clear, and otherwise to TBL_RD. DIR_WB writes the directory entry back (→TBL_RD). TBL_RD issues the leaf read (→TBL_WT). TBL_WT also has three exits. It goes to REPORT on a fault or when no write-back is needed, and to TBL_WB when a flag must be set. TBL_WB writes the leaf back (→REPORT). REPORT presents the result for one cycle (→IDLE).

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, mem_req_valid is 0 and done_valid is 0.
- R2: The directory entry is read at root + va[31:22]×4. The leaf entry is read at {directory entry[31:12], va[21:12], 2'b00}.
- R3: On success, done_paddr is {leaf entry[31:12], va[11:0]} and done_fault is 0.
- R4: If bit 0 (present) is clear in the directory entry or the leaf entry, the walk faults with fault_code[0]=0. A non-present directory entry causes no leaf read and no write.
- R5: A write faults with fault_code[0]=1 unless bit 1 (writable) is set in both the directory entry and the leaf entry. This rule applies in user and supervisor mode alike.
- R6: A user access faults with fault_code[0]=1 unless bit 2 (user) is set at both levels. A supervisor access ignores the user bit.
- R7: Bit 5 (accessed) is written back as 1 in a present directory entry, and in the leaf of a successful walk, only when it was 0. An entry whose bit 5 is already set is not rewritten. A write-back changes no other bit except bit 6 as given in R8.
- R8: A successful write sets bit 6 (dirty) in the leaf if it was clear. A read never sets bit 6. A walk issues at most two memory writes.
- R9: The root register loads from root_wr_base only when root_wr_en is high and root_wr_ring equals 0. Any other ring value leaves it unchanged.
- R10: A root load in the same cycle as the request acceptance, or later during the walk, does not affect that walk. Walks accepted afterwards use the new root.
- R11: A fault report gives fault_addr equal to the linear address and fault_code = {user, write, protection}, where bit 0 is 1 for a permission fault and 0 for a not-present fault.
- R12: Bits 11:9 of an entry are left for software. They do not affect the walk and are kept unchanged by write-backs.
- R13: While mem_req_valid is high and mem_req_ready is low, the request (valid, write, address) holds stable.
- R14: done_valid is a one-cycle pulse, and req_ready is 1 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_wr_en | input | 1 | Root register load strobe |
| root_wr_ring | input | 2 | Privilege ring of the loader; only 0 loads |
| root_wr_base | input | 32 | New directory base |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = word write, 0 = word read |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| done_valid | output | 1 | Result valid pulse |
| done_fault | output | 1 | Result is a page fault |
| done_paddr | output | 32 | Physical address (0 on fault) |
| fault_addr | output | 32 | Faulting linear address (0 on success) |
| fault_code | output | 3 | {user, write, protection} (0 on success) |

## Verification
Two functions can fall in the same cycle: a root load and a request acceptance. The bench raises root_wr_en with ring 0 in the very cycle that req_valid is taken. In another walk it raises the strobe two cycles into the walk. In both cases it expects the translation built from the old root, then a following walk built from the new root. A third case presents a ring-3 load and expects no change at all. Memory back-pressure is applied during these walks, so a stalled memory request and a root load also overlap.

// File: rtl/pt_pkg.sv
package pt_pkg;
    // entry flag positions
    localparam int FLG_P = 0;
    localparam int FLG_W = 1;
    localparam int FLG_U = 2;
    localparam int FLG_A = 5;
    localparam int FLG_D = 6;
    // fault code bit positions
    localparam int FC_PROT  = 0;
    localparam int FC_WRITE = 1;
    localparam int FC_USER  = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIR_RD,
        S_DIR_WT,
        S_DIR_WB,
        S_TBL_RD,
        S_TBL_WT,
        S_TBL_WB,
        S_REPORT
    } walk_state_t;
endpackage

// File: rtl/pt_root_reg.sv
module pt_root_reg #(
    parameter int ADDR_W = 32,
    parameter int RING_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RING_W-1:0] wr_ring,
    input  logic [ADDR_W-1:0] wr_base,
    output logic [ADDR_W-1:0] root
);
    logic [ADDR_W-1:0] root_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            root_q <= '0;
        end else if (wr_en && (wr_ring == '0)) begin
            root_q <= wr_base;
        end
    end

    assign root = root_q;

    // a load from a non-zero ring must leave the base untouched
    assert_ring_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_ring != '0)) |=> $stable(root_q));
endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12
) (
    input  logic [ADDR_W-1:0]       root,
    input  logic [IDX_W-1:0]        dir_idx,
    input  logic [ADDR_W-1:0]       va,
    input  logic [ADDR_W-OFF_W-1:0] dir_frame,
    input  logic [ADDR_W-OFF_W-1:0] leaf_frame,
    output logic [ADDR_W-1:0]       dir_addr,
    output logic [ADDR_W-1:0]       tbl_addr,
    output logic [ADDR_W-1:0]       phys_addr
);
    localparam int ENT_SH  = 2;
    localparam int PAD_W   = ADDR_W - IDX_W - ENT_SH;
    localparam int TIDX_LO = OFF_W;
    localparam int TIDX_HI = OFF_W + IDX_W - 1;

    logic [IDX_W-1:0] tbl_idx;

    assign tbl_idx   = va[TIDX_HI:TIDX_LO];
    assign dir_addr  = root + {{PAD_W{1'b0}}, dir_idx, {ENT_SH{1'b0}}};
    assign tbl_addr  = {dir_frame, tbl_idx, {ENT_SH{1'b0}}};
    assign phys_addr = {leaf_frame, va[OFF_W-1:0]};
endmodule

// File: rtl/pt_perm_check.sv
module pt_perm_check
    import pt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              dir_w,
    input  logic              dir_u,
    input  logic [ADDR_W-1:0] leaf,
    input  logic              is_write,
    input  logic              is_user,
    output logic              leaf_present,
    output logic              allow,
    output logic              leaf_wb,
    output logic [ADDR_W-1:0] leaf_new
);
    logic eff_w;
    logic eff_u;

    always_comb begin
        eff_w        = dir_w & leaf[FLG_W];
        eff_u        = dir_u & leaf[FLG_U];
        leaf_present = leaf[FLG_P];
        allow        = (!is_write || eff_w) && (!is_user || eff_u);
        leaf_new     = leaf;
        leaf_new[FLG_A] = 1'b1;
        if (is_write) begin
            leaf_new[FLG_D] = 1'b1;
        end
        leaf_wb      = (leaf_new != leaf);
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12,
    parameter int RING_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              root_wr_en,
    input  logic [RING_W-1:0] root_wr_ring,
    input  logic [ADDR_W-1:0] root_wr_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [ADDR_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_rdata,
    output logic              done_valid,
    output logic              done_fault,
    output logic [ADDR_W-1:0] done_paddr,
    output logic [ADDR_W-1:0] fault_addr,
    output logic [2:0]        fault_code
);
    localparam int FRAME_W = ADDR_W - OFF_W;
    localparam int DIDX_LO = ADDR_W - IDX_W;

    walk_state_t state_q, state_d;

    logic [ADDR_W-1:0] root;
    logic [ADDR_W-1:0] va_q;
    logic              wr_q;
    logic              usr_q;
    logic [ADDR_W-1:0] dir_addr_q;
    logic [ADDR_W-1:0] dent_q;
    logic [ADDR_W-1:0] tent_q;
    logic              fault_q;
    logic              prot_q;
    logic [1:0]        wr_cnt_q;

    logic [ADDR_W-1:0] dir_addr_new;
    logic [ADDR_W-1:0] tbl_addr;
    logic [ADDR_W-1:0] phys_addr;
    logic [ADDR_W-1:0] leaf_src;
    logic              leaf_present;
    logic              allow;
    logic              leaf_wb;
    logic [ADDR_W-1:0] leaf_new;
    logic [ADDR_W-1:0] dent_new;
    logic              accept;
    logic              mem_fire;

    pt_root_reg #(.ADDR_W(ADDR_W), .RING_W(RING_W)) u_root (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (root_wr_en),
        .wr_ring (root_wr_ring),
        .wr_base (root_wr_base),
        .root    (root)
    );

    pt_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
        .root       (root),
        .dir_idx    (req_vaddr[ADDR_W-1:DIDX_LO]),
        .va         (va_q),
        .dir_frame  (dent_q[ADDR_W-1:OFF_W]),
        .leaf_frame (tent_q[ADDR_W-1:OFF_W]),
        .dir_addr   (dir_addr_new),
        .tbl_addr   (tbl_addr),
        .phys_addr  (phys_addr)
    );

    // the leaf is judged as it arrives, and rebuilt from the copy for write-back
    assign leaf_src = (state_q == S_TBL_WT) ? mem_rsp_rdata : tent_q;

    pt_perm_check #(.ADDR_W(ADDR_W)) u_perm (
        .dir_w        (dent_q[FLG_W]),
        .dir_u        (dent_q[FLG_U]),
        .leaf         (leaf_src),
        .is_write     (wr_q),
        .is_user      (usr_q),
        .leaf_present (leaf_present),
        .allow        (allow),
        .leaf_wb      (leaf_wb),
        .leaf_new     (leaf_new)
    );

    always_comb begin
        dent_new        = dent_q;
        dent_new[FLG_A] = 1'b1;
    end

    assign accept   = (state_q == S_IDLE) && req_valid;
    assign mem_fire = mem_req_valid && mem_req_ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) state_d = S_DIR_RD;
            end
            S_DIR_RD: begin
                if (mem_req_ready) state_d = S_DIR_WT;
            end
            S_DIR_WT: begin
                if (mem_rsp_valid) begin
                    if (!mem_rsp_rdata[FLG_P])      state_d = S_REPORT;
                    else if (!mem_rsp_rdata[FLG_A]) state_d = S_DIR_WB;
                    else                            state_d = S_TBL_RD;
                end
            end
            S_DIR_WB: begin
                if (mem_req_ready) state_d = S_TBL_RD;
            end
            S_TBL_RD: begin
                if (mem_req_ready) state_d = S_TBL_WT;
            end
            S_TBL_WT: begin
                if (mem_rsp_valid) begin
                    if (!leaf_present || !allow) state_d = S_REPORT;
                    else if (leaf_wb)            state_d = S_TBL_WB;
                    else                         state_d = S_REPORT;
                end
            end
            S_TBL_WB: begin
                if (mem_req_ready) state_d = S_REPORT;
            end
            S_REPORT: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // walk context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q       <= '0;
            wr_q       <= 1'b0;
            usr_q      <= 1'b0;
            dir_addr_q <= '0;
            dent_q     <= '0;
            tent_q     <= '0;
            fault_q    <= 1'b0;
            prot_q     <= 1'b0;
            wr_cnt_q   <= '0;
        end else begin
            if (accept) begin
                va_q       <= req_vaddr;
                wr_q       <= req_write;
                usr_q      <= req_user;
                dir_addr_q <= dir_addr_new;
                fault_q    <= 1'b0;
                prot_q     <= 1'b0;
                wr_cnt_q   <= '0;
            end else if (mem_fire && mem_req_write) begin
                wr_cnt_q <= wr_cnt_q + 2'd1;
            end
            if ((state_q == S_DIR_WT) && mem_rsp_valid) begin
                dent_q <= mem_rsp_rdata;
                if (!mem_rsp_rdata[FLG_P]) fault_q <= 1'b1;
            end
            if ((state_q == S_TBL_WT) && mem_rsp_valid) begin
                tent_q <= mem_rsp_rdata;
                if (!leaf_present) begin
                    fault_q <= 1'b1;
                end else if (!allow) begin
                    fault_q <= 1'b1;
                    prot_q  <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        done_valid    = 1'b0;
        done_fault    = 1'b0;
        done_paddr    = '0;
        fault_addr    = '0;
        fault_code    = '0;
        unique case (state_q)
            S_IDLE: begin
                req_ready = 1'b1;
            end
            S_DIR_RD: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = dir_addr_q;
            end
            S_DIR_WT: begin
            end
            S_DIR_WB: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = dir_addr_q;
                mem_req_wdata = dent_new;
            end
            S_TBL_RD: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = tbl_addr;
            end
            S_TBL_WT: begin
            end
            S_TBL_WB: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = tbl_addr;
                mem_req_wdata = leaf_new;
            end
            S_REPORT: begin
                done_valid = 1'b1;
                done_fault = fault_q;
                if (fault_q) begin
                    fault_addr           = va_q;
                    fault_code[FC_PROT]  = prot_q;
                    fault_code[FC_WRITE] = wr_q;
                    fault_code[FC_USER]  = usr_q;
                end else begin
                    done_paddr = phys_addr;
                end
            end
            default: begin
            end
        endcase
    end

    // a stalled memory request keeps its contents
    assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    // every write-back marks the entry present and accessed
    assert_wb_marks_accessed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> (mem_req_wdata[FLG_A] && mem_req_wdata[FLG_P]));

    // no more than two writes in one walk
    assert_write_budget_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> (wr_cnt_q < 2'd2));

    // result is a single pulse followed by readiness
    assert_done_pulse_R14: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!done_valid && req_ready));

    // a fault always reports the captured address, never a physical one
    assert_fault_report_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault) |-> (done_paddr == '0));
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        root_wr_en = 1'b0;
    logic [1:0]  root_wr_ring = '0;
    logic [31:0] root_wr_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_rdata;
    logic        done_valid;
    logic        done_fault;
    logic [31:0] done_paddr;
    logic [31:0] fault_addr;
    logic [2:0]  fault_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n),
        .root_wr_en(root_wr_en), .root_wr_ring(root_wr_ring), .root_wr_base(root_wr_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata),
        .done_valid(done_valid), .done_fault(done_fault), .done_paddr(done_paddr),
        .fault_addr(fault_addr), .fault_code(fault_code)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // ---------------- memory model ----------------
    logic [31:0] mem [logic [31:0]];
    logic [31:0] exp_mem [logic [31:0]];
    logic        init_load = 1'b0;
    logic        stall_mode = 1'b0;
    logic        ready_q = 1'b1;
    logic        rsp_v = 1'b0;
    logic [31:0] rsp_d = '0;
    int unsigned cyc = 0;

    assign mem_req_ready = ready_q;
    assign mem_rsp_valid = rsp_v;
    assign mem_rsp_rdata = rsp_d;

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [31:0] em_rd(input logic [31:0] a);
        return exp_mem.exists(a) ? exp_mem[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        ready_q <= !stall_mode || ((cyc % 3) != 2);
        rsp_v <= 1'b0;
        if (init_load) begin
            mem = exp_mem;
        end else if (mem_req_valid && ready_q) begin
            if (mem_req_write) begin
                mem[mem_req_addr] = mem_req_wdata;
            end else begin
                rsp_v <= 1'b1;
                rsp_d <= mem_rd(mem_req_addr);
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic        fault;
        logic [31:0] paddr;
        logic [31:0] faddr;
        logic [2:0]  code;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   done_cnt = 0;
    int   wr_seen = 0;

    always @(negedge clk) begin
        if (rst_n && mem_req_valid && mem_req_ready && mem_req_write) wr_seen++;
        if (rst_n && done_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R14 unexpected result", 32'h1, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(done_fault == e.fault, {e.tag, " fault flag"}, {31'h0, done_fault}, {31'h0, e.fault});
                if (e.fault) begin
                    chk(fault_code == e.code, {e.tag, " R11 fault code"}, {29'h0, fault_code}, {29'h0, e.code});
                    chk(fault_addr == e.faddr, {e.tag, " R11 fault addr"}, fault_addr, e.faddr);
                end else begin
                    chk(done_paddr == e.paddr, {e.tag, " paddr"}, done_paddr, e.paddr);
                end
            end
            done_cnt++;
        end
    end

    logic [31:0] ref_root = '0;

    task automatic root_load(input logic [31:0] base, input logic [1:0] ring);
        @(negedge clk);
        root_wr_en = 1'b1; root_wr_base = base; root_wr_ring = ring;
        @(negedge clk);
        root_wr_en = 1'b0;
        if (ring == 2'd0) ref_root = base;
    endtask

    // driver: computes the expected outcome, pushes it, then drives the walk
    task automatic walk(input logic [31:0] va, input logic wr, input logic usr, input string tag,
                        input bit do_root = 1'b0, input int root_dly = 0,
                        input logic [31:0] rbase = 32'h0, input logic [1:0] rring = 2'd0);
        exp_t e;
        logic [31:0] da, ta, d, t, nt;
        int nwr, start, wr0;
        bit have_ta;
        nwr = 0; have_ta = 1'b0; ta = '0;
        e.tag = tag; e.faddr = va; e.paddr = '0; e.code = {usr, wr, 1'b0}; e.fault = 1'b0;
        da = ref_root + {20'h0, va[31:22], 2'b00};
        d = em_rd(da);
        if (!d[0]) begin
            e.fault = 1'b1;
        end else begin
            if (!d[5]) begin exp_mem[da] = d | 32'h20; nwr++; end
            ta = {d[31:12], va[21:12], 2'b00};
            have_ta = 1'b1;
            t = em_rd(ta);
            if (!t[0]) begin
                e.fault = 1'b1;
            end else if ((wr && !(d[1] && t[1])) || (usr && !(d[2] && t[2]))) begin
                e.fault = 1'b1;
                e.code[0] = 1'b1;
            end else begin
                e.paddr = {t[31:12], va[11:0]};
                nt = t | 32'h20 | (wr ? 32'h40 : 32'h0);
                if (nt != t) begin exp_mem[ta] = nt; nwr++; end
            end
        end
        exp_q.push_back(e);
        start = done_cnt;
        wr0 = wr_seen;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
        if (do_root && root_dly == 0) begin
            root_wr_en = 1'b1; root_wr_base = rbase; root_wr_ring = rring;
        end
        @(negedge clk);
        req_valid = 1'b0;
        root_wr_en = 1'b0;
        if (do_root && root_dly > 0) begin
            repeat (root_dly - 1) @(negedge clk);
            root_wr_en = 1'b1; root_wr_base = rbase; root_wr_ring = rring;
            @(negedge clk);
            root_wr_en = 1'b0;
        end
        while (done_cnt == start) @(negedge clk);
        @(negedge clk);
        chk(!done_valid && req_ready, {tag, " R14 pulse then ready"}, {31'h0, done_valid}, 32'h0);
        chk((wr_seen - wr0) == nwr, {tag, " R8 write count"}, wr_seen - wr0, nwr);
        chk(mem_rd(da) == em_rd(da), {tag, " R7 directory entry"}, mem_rd(da), em_rd(da));
        if (have_ta)
            chk(mem_rd(ta) == em_rd(ta), {tag, " R7 leaf entry"}, mem_rd(ta), em_rd(ta));
        if (do_root && rring == 2'd0) ref_root = rbase;
    endtask

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired R14 actual=%h expected=%h", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        // directory under root A (0x10000)
        exp_mem[32'h0001_0004] = 32'h0003_0007;
        exp_mem[32'h0001_000C] = 32'h0004_0023;
        exp_mem[32'h0001_0010] = 32'h0004_0005;
        // directory under root B (0x20000)
        exp_mem[32'h0002_0004] = 32'h0003_1027;
        // leaf tables
        exp_mem[32'h0003_0004] = 32'h0005_5007;
        exp_mem[32'h0003_0008] = 32'h0006_6E05;
        exp_mem[32'h0003_000C] = 32'h0007_7002;
        exp_mem[32'h0004_0000] = 32'h0008_8007;
        exp_mem[32'h0004_0004] = 32'h0009_9007;
        exp_mem[32'h0003_1004] = 32'h000A_A027;

        init_load = 1'b1;
        repeat (3) @(negedge clk);
        init_load = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 req_ready", {31'h0, req_ready}, 32'h1);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
        chk(done_valid == 1'b0, "R1 done_valid", {31'h0, done_valid}, 32'h0);

        root_load(32'h0001_0000, 2'd0);

        walk(32'h0040_1123, 1'b0, 1'b1, "R2 R3 R7 first use");
        walk(32'h0040_1123, 1'b1, 1'b1, "R8 dirty on write");
        walk(32'h0040_1123, 1'b0, 1'b0, "R7 no rewrite");
        walk(32'h0040_2ABC, 1'b1, 1'b1, "R5 leaf read-only");
        walk(32'h0040_2ABC, 1'b0, 1'b1, "R12 software bits");
        walk(32'h0080_0010, 1'b0, 1'b0, "R4 directory absent");
        walk(32'h0040_3044, 1'b1, 1'b0, "R4 leaf absent");
        walk(32'h00C0_0200, 1'b0, 1'b1, "R6 user denied at directory");
        walk(32'h00C0_0200, 1'b1, 1'b0, "R6 supervisor ignores user bit");
        walk(32'h0100_1010, 1'b1, 1'b1, "R5 directory read-only");
        walk(32'h0100_1010, 1'b0, 1'b1, "R6 user read allowed");

        stall_mode = 1'b1;
        root_load(32'h0002_0000, 2'd3);
        walk(32'h0040_1123, 1'b0, 1'b0, "R9 R13 ring 3 load ignored");
        walk(32'h0040_1123, 1'b0, 1'b0, "R10 R13 same-cycle load", 1'b1, 0, 32'h0002_0000, 2'd0);
        walk(32'h0040_1123, 1'b0, 1'b0, "R10 new root used");
        walk(32'h0040_1123, 1'b0, 1'b0, "R10 mid-walk load", 1'b1, 2, 32'h0001_0000, 2'd0);
        stall_mode = 1'b0;
        walk(32'h0040_1123, 1'b1, 1'b0, "R10 R3 back on first root");

        chk(exp_q.size() == 0, "R14 results outstanding", exp_q.size(), 32'h0);
        finish_run();
    end
endmodule